// File: doc/BRIEF.md
# Processor Sleep-State Sequencer

This block is system-side core logic that walks a group of processors from Stop-Grant into the deep Sleep state and brings them back. When a low-power request arrives with no wake event pending, it drives the active-low stop-clock control. It then waits until every processor has reported that its Stop-Grant bus cycle is complete. After that it blocks bus traffic, counts a fixed guard interval of bus clocks, and drives the active-low sleep control. A second interval later the processors count as asleep, and only then is the interrupt-controller clock gated off.

An interrupt or snoop request that arrives while asleep, or during the entry settle, is recorded. It releases the sleep control, and bus traffic stays blocked until the exit settle interval has run out. An interrupt wake also releases stop-clock, so the processors go back to normal operation. A snoop-only wake leaves the processors in Stop-Grant until the snoop clears, and then sleep is entered again. A processor reset request while asleep releases both controls at once.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: After controller reset, stpclk_n=1, slp_n=1, bus_block=0 and picclk_en=1.
- R2: With lp_req=1 and no wake input high, stpclk_n goes low one cycle later. Sleep entry is held off until bit i of sg_done (processor i) has been seen high for every i. Bits may arrive in any cycles and in any order, as pulses or as levels.
- R3: bus_block rises in the cycle after the last completion bit is seen. slp_n falls ENTRY_GUARD cycles after bus_block rises.
- R4: picclk_en falls SLEEP_SETTLE cycles after slp_n falls, and is low only while the processors are asleep.
- R5: bus_block stays high for the whole of the guard interval, the entry settle, the Sleep state and the exit settle.
- R6: An interrupt or snoop wake seen while asleep raises slp_n in the next cycle. A wake pulse seen during the entry settle is remembered and acted on in the first asleep cycle. bus_block falls EXIT_SETTLE cycles after slp_n rises.
- R7: On an interrupt wake, stpclk_n rises one cycle after bus_block falls.
- R8: On a snoop-only wake with lp_req held high, stpclk_n stays low and bus_block stays low while wake_snoop remains high. When wake_snoop drops, the guard interval restarts and sleep is entered again with R3 timing.
- R9: wake_rst seen while asleep raises both slp_n and stpclk_n in the next cycle, drops bus_block and raises picclk_en.
- R10: lp_req is ignored while any wake input is high. All outputs keep their normal values.
- R11: A wake input or a drop of lp_req during the completion wait or the guard interval returns the block to normal in the next cycle (stpclk_n=1, bus_block=0). The record of completion bits is cleared.
- R12: slp_n is never low while stpclk_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low controller reset |
| lp_req | input | 1 | Low-power request from system logic |
| sg_done | input | NUM_CPU | Per-processor Stop-Grant cycle complete |
| wake_irq | input | 1 | Pending interrupt wake event |
| wake_snoop | input | 1 | Pending snoop request wake event |
| wake_rst | input | 1 | Processor reset request wake event |
| stpclk_n | output | 1 | Active-low stop-clock control |
| slp_n | output | 1 | Active-low sleep control |
| bus_block | output | 1 | Block bus transactions while high |
| picclk_en | output | 1 | Interrupt-controller clock enable |

## Verification
The bench builds the block with NUM_CPU=3, ENTRY_GUARD=6, SLEEP_SETTLE=3 and EXIT_SETTLE=4. With short intervals, every edge of each window can be checked one cycle at a time: the last cycle before an output moves and the cycle it moves. Three processors allow completion bits to arrive out of order, leave one bit missing, and check that the record is cleared after an abort. A settle interval of three cycles leaves room to inject a wake pulse in the middle of the entry settle.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_SG_WAIT,
        ST_GUARD,
        ST_ENTER,
        ST_ASLEEP,
        ST_EXIT,
        ST_RESUME
    } seq_state_e;

    typedef struct packed {
        logic stpclk_n;
        logic slp_n;
        logic bus_block;
        logic picclk_en;
    } seq_out_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic seq_out_t decode_out(input seq_state_e st);
        seq_out_t o;
        o.stpclk_n  = (st == ST_NORMAL);
        o.slp_n     = !(st == ST_ENTER || st == ST_ASLEEP);
        o.bus_block = (st == ST_GUARD || st == ST_ENTER ||
                       st == ST_ASLEEP || st == ST_EXIT);
        o.picclk_en = (st != ST_ASLEEP);
        return o;
    endfunction

endpackage

// File: rtl/sleep_seq_grant_mask.sv
module sleep_seq_grant_mask #(
    parameter int NUM_CPU = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               capture,
    input  logic [NUM_CPU-1:0] sg_done,
    output logic               all_done
);
    logic [NUM_CPU-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (clear) begin
            mask_d = '0;
        end else if (capture) begin
            mask_d = mask_q | sg_done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign all_done = &(mask_q | sg_done);

endmodule

// File: rtl/sleep_seq_timer.sv
module sleep_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sleep_seq_wake_latch.sv
module sleep_seq_wake_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic wake_irq,
    input  logic wake_snoop,
    input  logic wake_rst,
    output logic pend_irq,
    output logic pend_snoop,
    output logic pend_rst
);
    typedef struct packed {
        logic irq;
        logic snoop;
        logic rst;
    } wake_vec_t;

    wake_vec_t lat_d, lat_q;

    always_comb begin
        lat_d = '0;
        if (arm) begin
            lat_d.irq   = lat_q.irq   | wake_irq;
            lat_d.snoop = lat_q.snoop | wake_snoop;
            lat_d.rst   = lat_q.rst   | wake_rst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign pend_irq   = lat_q.irq   | wake_irq;
    assign pend_snoop = lat_q.snoop | wake_snoop;
    assign pend_rst   = lat_q.rst   | wake_rst;

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int NUM_CPU      = 2,
    parameter int ENTRY_GUARD  = 100,
    parameter int SLEEP_SETTLE = 10,
    parameter int EXIT_SETTLE  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lp_req,
    input  logic [NUM_CPU-1:0] sg_done,
    input  logic               wake_irq,
    input  logic               wake_snoop,
    input  logic               wake_rst,
    output logic               stpclk_n,
    output logic               slp_n,
    output logic               bus_block,
    output logic               picclk_en
);
    localparam int MAX_INTERVAL = max3(ENTRY_GUARD, SLEEP_SETTLE, EXIT_SETTLE);
    localparam int CNT_W        = $clog2(MAX_INTERVAL + 1);
    localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(ENTRY_GUARD - 1);
    localparam logic [CNT_W-1:0] ENTER_LOAD = CNT_W'(SLEEP_SETTLE - 1);
    localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_SETTLE - 1);

    typedef struct packed {
        seq_state_e st;
        seq_out_t   outs;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic             all_done;
    logic             expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             pend_irq, pend_snoop, pend_rst;
    logic             any_wake;
    logic             latch_arm;

    assign any_wake  = wake_irq | wake_snoop | wake_rst;
    assign latch_arm = (r_q.st == ST_ENTER) || (r_q.st == ST_ASLEEP) || (r_q.st == ST_EXIT);

    sleep_seq_grant_mask #(.NUM_CPU(NUM_CPU)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (r_q.st != ST_SG_WAIT),
        .capture  (r_q.st == ST_SG_WAIT),
        .sg_done  (sg_done),
        .all_done (all_done)
    );

    sleep_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    sleep_seq_wake_latch u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (latch_arm),
        .wake_irq   (wake_irq),
        .wake_snoop (wake_snoop),
        .wake_rst   (wake_rst),
        .pend_irq   (pend_irq),
        .pend_snoop (pend_snoop),
        .pend_rst   (pend_rst)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_NORMAL: begin
                if (lp_req && !any_wake) r_d.st = ST_SG_WAIT;
            end
            ST_SG_WAIT: begin
                if (any_wake || !lp_req) r_d.st = ST_NORMAL;
                else if (all_done)       r_d.st = ST_GUARD;
            end
            ST_GUARD: begin
                if (any_wake || !lp_req) r_d.st = ST_NORMAL;
                else if (expired)        r_d.st = ST_ENTER;
            end
            ST_ENTER: begin
                if (expired) r_d.st = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (pend_rst)                    r_d.st = ST_NORMAL;
                else if (pend_irq || pend_snoop) r_d.st = ST_EXIT;
            end
            ST_EXIT: begin
                if (expired) r_d.st = ST_RESUME;
            end
            ST_RESUME: begin
                if (pend_irq || pend_rst || !lp_req) r_d.st = ST_NORMAL;
                else if (!wake_snoop)                r_d.st = ST_GUARD;
            end
            default: r_d.st = ST_NORMAL;
        endcase

        if (r_d.st != r_q.st) begin
            unique case (r_d.st)
                ST_GUARD: begin tmr_load = 1'b1; tmr_val = GUARD_LOAD; end
                ST_ENTER: begin tmr_load = 1'b1; tmr_val = ENTER_LOAD; end
                ST_EXIT:  begin tmr_load = 1'b1; tmr_val = EXIT_LOAD;  end
                default:  begin tmr_load = 1'b0; tmr_val = '0;         end
            endcase
        end

        r_d.outs = decode_out(r_d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_NORMAL;
            r_q.outs <= decode_out(ST_NORMAL);
        end else begin
            r_q <= r_d;
        end
    end

    assign stpclk_n  = r_q.outs.stpclk_n;
    assign slp_n     = r_q.outs.slp_n;
    assign bus_block = r_q.outs.bus_block;
    assign picclk_en = r_q.outs.picclk_en;

endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic lp_req,
    input logic wake_rst,
    input logic stpclk_n,
    input logic slp_n,
    input logic bus_block,
    input logic picclk_en
);
    // R12
    slp_needs_stpclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_n |-> !stpclk_n);

    // R4
    picclk_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !picclk_en |-> !slp_n);

    // R5
    sleep_entry_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slp_n) |-> bus_block && $past(bus_block));

    // R5
    asleep_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slp_n |-> bus_block);

    // R6
    exit_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slp_n) && !stpclk_n |-> bus_block);

    // R2
    stpclk_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stpclk_n) |-> $past(lp_req));

    // R9
    reset_wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wake_rst) && !$past(picclk_en) |-> slp_n && stpclk_n && !bus_block);

endmodule

bind sleep_seq_ctrl sleep_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lp_req    (lp_req),
    .wake_rst  (wake_rst),
    .stpclk_n  (stpclk_n),
    .slp_n     (slp_n),
    .bus_block (bus_block),
    .picclk_en (picclk_en)
);

// File: tb/sim_sleep_seq_ctrl.sv
module sim_sleep_seq_ctrl;
    localparam int N = 3;
    localparam int G = 6;
    localparam int S = 3;
    localparam int E = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lp_req = 1'b0;
    logic [N-1:0] sg_done = '0;
    logic         wake_irq = 1'b0, wake_snoop = 1'b0, wake_rst = 1'b0;
    logic         stpclk_n, slp_n, bus_block, picclk_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sleep_seq_ctrl #(.NUM_CPU(N), .ENTRY_GUARD(G), .SLEEP_SETTLE(S), .EXIT_SETTLE(E)) u0 (
        .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .sg_done(sg_done),
        .wake_irq(wake_irq), .wake_snoop(wake_snoop), .wake_rst(wake_rst),
        .stpclk_n(stpclk_n), .slp_n(slp_n), .bus_block(bus_block), .picclk_en(picclk_en)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_outs(input string req, input logic e_stp, input logic e_slp,
                            input logic e_blk, input logic e_pic);
        chk(stpclk_n == e_stp, req, "stpclk_n", int'(stpclk_n), int'(e_stp));
        chk(slp_n == e_slp, req, "slp_n", int'(slp_n), int'(e_slp));
        chk(bus_block == e_blk, req, "bus_block", int'(bus_block), int'(e_blk));
        chk(picclk_en == e_pic, req, "picclk_en", int'(picclk_en), int'(e_pic));
    endtask

    // From guard start (k=1 already observed) to the first asleep cycle
    task automatic check_entry_timing();
        for (int k = 2; k <= G; k++) begin
            step();
            chk(slp_n == 1'b1 && bus_block == 1'b1, "R3", "slp_n before guard end",
                int'(slp_n), 1);
        end
        step();
        chk(slp_n == 1'b0, "R3", "slp_n at guard end", int'(slp_n), 0);
        chk(stpclk_n == 1'b0, "R12", "stpclk_n while sleep driven", int'(stpclk_n), 0);
        for (int j = 1; j < S; j++) begin
            step();
            chk(picclk_en == 1'b1, "R4", "picclk_en during settle", int'(picclk_en), 1);
        end
        step();
        chk_outs("R4", 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic enter_to_sleep(input string order_tag);
        lp_req = 1'b1;
        step();
        chk(stpclk_n == 1'b0, "R2", "stpclk_n after request", int'(stpclk_n), 0);
        for (int i = N - 1; i >= 0; i--) begin
            sg_done = N'(1) << i;
            step();
            sg_done = '0;
            if (i != 0) chk(bus_block == 1'b0, "R2", {"no block before all done ", order_tag},
                            int'(bus_block), 0);
        end
        chk(bus_block == 1'b1 && slp_n == 1'b1, "R3", "block rises after last done",
            int'(bus_block), 1);
        check_entry_timing();
    endtask

    // Called right after slp_n rose (exit state, relative cycle 1)
    task automatic finish_exit(input bit irq_wake);
        chk(bus_block == 1'b1 && picclk_en == 1'b1, "R6", "exit start", int'(bus_block), 1);
        for (int j = 1; j < E; j++) begin
            step();
            chk(bus_block == 1'b1, "R5", "block during exit", int'(bus_block), 1);
        end
        step();
        chk(bus_block == 1'b0, "R6", "block released after exit", int'(bus_block), 0);
        chk(stpclk_n == 1'b0, "R7", "stpclk_n still low at release", int'(stpclk_n), 0);
        if (irq_wake) begin
            step();
            chk(stpclk_n == 1'b1, "R7", "stpclk_n after irq resume", int'(stpclk_n), 1);
        end
    endtask

    task automatic t_reset();
        chk_outs("R1", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_irq_cycle();
        enter_to_sleep("desc");
        step();
        chk_outs("R5", 1'b0, 1'b0, 1'b1, 1'b0);
        wake_irq = 1'b1;
        lp_req   = 1'b0;
        step();
        wake_irq = 1'b0;
        chk(slp_n == 1'b1, "R6", "slp_n after irq", int'(slp_n), 1);
        finish_exit(1'b1);
        step();
        chk_outs("R1", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_partial();
        lp_req = 1'b1;
        step();
        sg_done = 3'b001; step();
        sg_done = 3'b100; step();
        sg_done = '0;
        for (int k = 0; k < G + S + 2; k++) begin
            step();
            chk(slp_n == 1'b1 && bus_block == 1'b0, "R2", "held off with one missing",
                int'(bus_block), 0);
        end
        sg_done = 3'b010;
        step();
        sg_done = '0;
        chk(bus_block == 1'b1, "R3", "block after late completion", int'(bus_block), 1);
        lp_req = 1'b0;
        step();
        chk_outs("R11", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_wake_in_entry();
        lp_req = 1'b1;
        step();
        sg_done = '1;
        step();
        sg_done = '0;
        chk(bus_block == 1'b1, "R3", "level completion", int'(bus_block), 1);
        for (int k = 2; k <= G; k++) step();
        step();
        chk(slp_n == 1'b0, "R3", "slp_n falls", int'(slp_n), 0);
        wake_irq = 1'b1;
        lp_req   = 1'b0;
        step();
        wake_irq = 1'b0;
        for (int j = 2; j < S; j++) step();
        step();
        chk(picclk_en == 1'b0 && slp_n == 1'b0, "R6", "asleep despite early wake",
            int'(picclk_en), 0);
        step();
        chk(slp_n == 1'b1, "R6", "remembered wake exits", int'(slp_n), 1);
        finish_exit(1'b1);
    endtask

    task automatic t_snoop();
        enter_to_sleep("desc2");
        wake_snoop = 1'b1;
        step();
        chk(slp_n == 1'b1, "R6", "slp_n after snoop", int'(slp_n), 1);
        finish_exit(1'b0);
        for (int k = 0; k < 3; k++) begin
            step();
            chk(stpclk_n == 1'b0 && bus_block == 1'b0, "R8", "held in stop-grant for snoop",
                int'(bus_block), 0);
        end
        wake_snoop = 1'b0;
        step();
        chk(bus_block == 1'b1 && stpclk_n == 1'b0, "R8", "guard restarts", int'(bus_block), 1);
        check_entry_timing();
        wake_irq = 1'b1;
        lp_req   = 1'b0;
        step();
        wake_irq = 1'b0;
        finish_exit(1'b1);
    endtask

    task automatic t_reset_wake();
        enter_to_sleep("desc3");
        wake_rst = 1'b1;
        lp_req   = 1'b0;
        step();
        wake_rst = 1'b0;
        chk_outs("R9", 1'b1, 1'b1, 1'b0, 1'b1);
        step();
        chk_outs("R9", 1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_ignore();
        wake_snoop = 1'b1;
        lp_req     = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk_outs("R10", 1'b1, 1'b1, 1'b0, 1'b1);
        end
        wake_snoop = 1'b0;
        wake_irq   = 1'b1;
        step();
        chk(stpclk_n == 1'b1, "R10", "irq held ignores request", int'(stpclk_n), 1);
        wake_irq = 1'b0;
        lp_req   = 1'b0;
        step();
    endtask

    task automatic t_abort();
        lp_req = 1'b1;
        step();
        sg_done = 3'b001;
        step();
        sg_done = '0;
        wake_irq = 1'b1;
        step();
        wake_irq = 1'b0;
        chk(stpclk_n == 1'b1, "R11", "wake aborts completion wait", int'(stpclk_n), 1);
        step();
        chk(stpclk_n == 1'b0, "R11", "new request accepted", int'(stpclk_n), 0);
        sg_done = 3'b110;
        step();
        sg_done = '0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(bus_block == 1'b0, "R11", "record cleared after abort", int'(bus_block), 0);
        end
        sg_done = 3'b001;
        step();
        sg_done = '0;
        chk(bus_block == 1'b1, "R11", "guard starts", int'(bus_block), 1);
        step();
        wake_snoop = 1'b1;
        step();
        wake_snoop = 1'b0;
        chk_outs("R11", 1'b1, 1'b1, 1'b0, 1'b1);
        lp_req = 1'b0;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_irq_cycle();
        t_partial();
        t_wake_in_entry();
        t_snoop();
        t_reset_wake();
        t_ignore();
        t_abort();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule